// File: doc/BRIEF.md
# Trigger Pipeline Readout Address Sequencer

The block produces the circular write address for a front-end data pipeline. When a trigger is accepted, it also produces the addresses used to copy a window of that pipeline into a dual-port memory buffer.

While idle, the pipeline address follows a free-running slot count. This count wraps after a programmable end value. In external mode, a bunch-zero pulse resets the count.

On an accepted trigger the block works out a trigger address. In local mode this is the current pipeline address. In external mode it is derived from the crossing number. The block then steps back by the jumpback offset and replays `window end + 1` consecutive pipeline addresses. During that replay an active-low transfer flag is held, and the memory address walks through the window slots of the selected buffer.

The free count keeps advancing during the replay. When the replay ends, the pipeline address picks the count up again. Configuration can only be written while the block is in standby and no copy is running.

All pins are plain control and status levels or strobes sampled on the clock. No stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `psq_top`

## Requirements
- R1: Out of reset, `pipe_addr` is 0. While idle it equals a slot count that rises by 1 per clock and goes to 0 on the clock after it equals the pipeline end value (or exceeds it).
- R2: With `ext_ctrl`=1, a `bc_zero` pulse makes the slot count 0 on the following clock. This also happens during a transfer.
- R3: The trigger address is captured on accept and shown on `trig_addr`. In local mode it is the pipeline address in the accept cycle. In external mode it is 2·`xing_num`−1, minus (pipe end+1) when that exceeds pipe end. A crossing number of 0 gives the pipe end value.
- R4: On the `window end + 1` clocks after an accept, `pipe_addr` shows the trigger address minus jumpback, modulo (pipe end+1), then the following addresses in turn, wrapping after pipe end. Jumpback must not exceed pipe end.
- R5: `xfer_n` is low for exactly `window end + 1` clocks, starting on the clock after the accept.
- R6: `mem_addr` is 0x7FF when idle. Bits [10:7] carry the buffer number captured at accept and bits [6:0] the window slot. It lags the flag by one clock: 0x7FF in the first transfer cycle, then slot k−1 in transfer cycle k, then the last slot for one clock after `xfer_n` rises.
- R7: When a transfer ends, `endcopy_addr` holds the last pipeline address read, which is (trigger − jumpback + window end) modulo (pipe end+1).
- R8: On the clock after the transfer ends, `pipe_addr` equals the slot count, which kept advancing through the transfer.
- R9: Pipe end, jumpback and window end reset to 439, 6 and 3. `cfg_load` updates them only while `standby`=1 and no transfer runs. Otherwise it has no effect.
- R10: An accept while `standby`=1 starts no transfer and does not set overflow.
- R11: An accept while a transfer runs is ignored: the copy in progress continues unchanged. It sets `overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby state: enables configuration writes and blocks accepts |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_pipe_end | input | 10 | Pipeline length minus 1 |
| cfg_jumpback | input | 10 | Step back from the trigger address |
| cfg_win_end | input | 7 | Window length minus 1 |
| ext_ctrl | input | 1 | 1 = external trigger control, 0 = local |
| bc_zero | input | 1 | Bunch-zero sync pulse (used only in external mode) |
| accept | input | 1 | Trigger accept strobe |
| xing_num | input | 9 | Crossing number of the accepted trigger (external mode) |
| buf_num | input | 4 | Buffer number for the copy |
| pipe_addr | output | 10 | Pipeline address |
| xfer_n | output | 1 | Active-low transfer flag |
| mem_addr | output | 11 | Dual-port memory address: buffer field and window field |
| trig_addr | output | 10 | Captured trigger address |
| endcopy_addr | output | 10 | Captured end-copy address |
| overflow | output | 1 | Sticky flag: accept arrived during a transfer |

## Verification
Two situations can land in the same clock.

The first is a bunch-zero reset of the slot count while a transfer is replaying. The bench raises `bc_zero` in the second transfer cycle of half the external-mode sweeps. It then checks that the replayed addresses do not change and that `pipe_addr` resumes from the count that was zeroed.

The second is a new accept arriving while a copy is running, including the single-entry window, where that cycle is also the copy's last. The bench checks that the copy runs out unchanged, with its length, addresses and end-copy value intact, and that `overflow` is set.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int PA_W_DEF = 10;
  localparam int WA_W_DEF = 7;
  localparam int BA_W_DEF = 4;

  typedef enum logic {
    TRIG_LOCAL = 1'b0,
    TRIG_EXT   = 1'b1
  } trig_src_e;
endpackage

// File: rtl/psq_cfg_regs.sv
module psq_cfg_regs #(
  parameter int PA_W   = 10,
  parameter int WA_W   = 7,
  parameter int DEF_PE = 439,
  parameter int DEF_JB = 6,
  parameter int DEF_WE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PA_W-1:0] pe_in,
  input  logic [PA_W-1:0] jb_in,
  input  logic [WA_W-1:0] we_in,
  output logic [PA_W-1:0] pe_q,
  output logic [PA_W-1:0] jb_q,
  output logic [WA_W-1:0] we_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q <= PA_W'(DEF_PE);
      jb_q <= PA_W'(DEF_JB);
      we_q <= WA_W'(DEF_WE);
    end else if (load_en) begin
      pe_q <= pe_in;
      jb_q <= jb_in;
      we_q <= we_in;
    end
  end
endmodule

// File: rtl/psq_free_count.sv
module psq_free_count #(
  parameter int PA_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zero,
  input  logic [PA_W-1:0] pe,
  output logic [PA_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (zero)      cnt <= '0;
    else if (cnt >= pe) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psq_trig_calc.sv
module psq_trig_calc
  import psq_pkg::*;
#(
  parameter int PA_W = 10
) (
  input  trig_src_e       src,
  input  logic [PA_W-1:0] cnt,
  input  logic [PA_W-2:0] xing,
  input  logic [PA_W-1:0] pe,
  input  logic [PA_W-1:0] jb,
  output logic [PA_W-1:0] trig,
  output logic [PA_W-1:0] start
);
  logic [PA_W:0] dbl;
  logic [PA_W:0] size;
  logic [PA_W:0] back;

  assign size = {1'b0, pe} + 1'b1;
  assign dbl  = {1'b0, xing, 1'b0} - 1'b1;

  always_comb begin
    if (src == TRIG_LOCAL)    trig = cnt;
    else if (xing == '0)      trig = pe;
    else if (dbl > {1'b0, pe}) trig = PA_W'(dbl - size);
    else                      trig = PA_W'(dbl);
  end

  always_comb begin
    if (trig >= jb) back = {1'b0, trig} - {1'b0, jb};
    else            back = {1'b0, trig} + size - {1'b0, jb};
    start = PA_W'(back);
  end
endmodule

// File: rtl/psq_window_seq.sv
module psq_window_seq #(
  parameter int PA_W = 10,
  parameter int WA_W = 7,
  parameter int BA_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [PA_W-1:0]      start,
  input  logic [PA_W-1:0]      trig,
  input  logic [BA_W-1:0]      buf_in,
  input  logic [PA_W-1:0]      pe,
  input  logic [WA_W-1:0]      we,
  output logic                 busy,
  output logic [PA_W-1:0]      rd_addr,
  output logic [PA_W-1:0]      trig_q,
  output logic [PA_W-1:0]      endc_q,
  output logic [BA_W+WA_W-1:0] mem_q
);
  logic [WA_W-1:0] widx;
  logic [BA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_addr <= '0;
      widx    <= '0;
      trig_q  <= '0;
      endc_q  <= '0;
      buf_q   <= '1;
      mem_q   <= '1;
    end else begin
      mem_q <= busy ? {buf_q, widx} : '1;
      if (go) begin
        busy    <= 1'b1;
        rd_addr <= start;
        widx    <= '0;
        trig_q  <= trig;
        buf_q   <= buf_in;
      end else if (busy) begin
        if (widx == we) begin
          busy   <= 1'b0;
          endc_q <= rd_addr;
        end else begin
          widx    <= widx + 1'b1;
          rd_addr <= (rd_addr >= pe) ? '0 : rd_addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psq_top.sv
module psq_top
  import psq_pkg::*;
#(
  parameter int PA_W   = PA_W_DEF,
  parameter int WA_W   = WA_W_DEF,
  parameter int BA_W   = BA_W_DEF,
  parameter int DEF_PE = 439,
  parameter int DEF_JB = 6,
  parameter int DEF_WE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 cfg_load,
  input  logic [PA_W-1:0]      cfg_pipe_end,
  input  logic [PA_W-1:0]      cfg_jumpback,
  input  logic [WA_W-1:0]      cfg_win_end,
  input  logic                 ext_ctrl,
  input  logic                 bc_zero,
  input  logic                 accept,
  input  logic [PA_W-2:0]      xing_num,
  input  logic [BA_W-1:0]      buf_num,
  output logic [PA_W-1:0]      pipe_addr,
  output logic                 xfer_n,
  output logic [BA_W+WA_W-1:0] mem_addr,
  output logic [PA_W-1:0]      trig_addr,
  output logic [PA_W-1:0]      endcopy_addr,
  output logic                 overflow
);
  logic [PA_W-1:0] cfg_pe_q, cfg_jb_q;
  logic [WA_W-1:0] cfg_we_q;
  logic [PA_W-1:0] slot_cnt, trig_c, start_c, rd_addr;
  logic            busy, go, load_en;
  trig_src_e       src;

  assign src     = ext_ctrl ? TRIG_EXT : TRIG_LOCAL;
  assign load_en = standby && cfg_load && !busy;
  assign go      = accept && !standby && !busy;

  psq_cfg_regs #(
    .PA_W(PA_W), .WA_W(WA_W), .DEF_PE(DEF_PE), .DEF_JB(DEF_JB), .DEF_WE(DEF_WE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .pe_in(cfg_pipe_end), .jb_in(cfg_jumpback), .we_in(cfg_win_end),
    .pe_q(cfg_pe_q), .jb_q(cfg_jb_q), .we_q(cfg_we_q)
  );

  psq_free_count #(.PA_W(PA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero(ext_ctrl && bc_zero),
    .pe(cfg_pe_q), .cnt(slot_cnt)
  );

  psq_trig_calc #(.PA_W(PA_W)) u_trig (
    .src(src), .cnt(slot_cnt), .xing(xing_num), .pe(cfg_pe_q),
    .jb(cfg_jb_q), .trig(trig_c), .start(start_c)
  );

  psq_window_seq #(.PA_W(PA_W), .WA_W(WA_W), .BA_W(BA_W)) u_win (
    .clk(clk), .rst_n(rst_n), .go(go), .start(start_c), .trig(trig_c),
    .buf_in(buf_num), .pe(cfg_pe_q), .we(cfg_we_q), .busy(busy),
    .rd_addr(rd_addr), .trig_q(trig_addr), .endc_q(endcopy_addr),
    .mem_q(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                             overflow <= 1'b0;
    else if (accept && !standby && busy)    overflow <= 1'b1;
  end

  assign pipe_addr = busy ? rd_addr : slot_cnt;
  assign xfer_n    = !busy;
endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
  parameter int PA_W = 10,
  parameter int WA_W = 7,
  parameter int BA_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ext_ctrl,
  input logic                 bc_zero,
  input logic [PA_W-1:0]      pipe_addr,
  input logic                 xfer_n,
  input logic [BA_W+WA_W-1:0] mem_addr,
  input logic                 overflow,
  input logic [PA_W-1:0]      pe,
  input logic [WA_W-1:0]      we
);
  logic [WA_W:0] low_len;

  always_ff @(posedge clk) begin
    if (!rst_n || xfer_n) low_len <= '0;
    else                  low_len <= low_len + 1'b1;
  end

  AST_PIPE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && !(ext_ctrl && bc_zero) && pipe_addr < pe)
    |=> (!xfer_n || pipe_addr == $past(pipe_addr) + 1'b1)); // R1

  AST_BCZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && ext_ctrl && bc_zero) |=> (!xfer_n || pipe_addr == '0)); // R2

  AST_XFER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_n) |-> (low_len == {1'b0, we} + 1'b1)); // R5

  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_n && $past(xfer_n)) |-> (mem_addr == '1)); // R6

  AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_n && !$past(xfer_n))
    |-> (mem_addr[WA_W-1:0] == $past(mem_addr[WA_W-1:0]) + 1'b1)); // R6

  AST_NO_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R11
endmodule

bind psq_top psq_checker #(.PA_W(PA_W), .WA_W(WA_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_ctrl(ext_ctrl), .bc_zero(bc_zero),
  .pipe_addr(pipe_addr), .xfer_n(xfer_n), .mem_addr(mem_addr),
  .overflow(overflow), .pe(cfg_pe_q), .we(cfg_we_q)
);

// File: tb/tb_psq_top.sv
`timescale 1ns/1ps
module tb_psq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, cfg_load = 1'b0;
  logic [9:0]  cfg_pipe_end = '0, cfg_jumpback = '0;
  logic [6:0]  cfg_win_end = '0;
  logic        ext_ctrl = 1'b0, bc_zero = 1'b0, accept = 1'b0;
  logic [8:0]  xing_num = '0;
  logic [3:0]  buf_num = '0;
  logic [9:0]  pipe_addr, trig_addr, endcopy_addr;
  logic        xfer_n, overflow;
  logic [10:0] mem_addr;

  int n_tests = 0, n_fail = 0;
  int exp_cnt = 0;
  int m_pe = 439, m_jb = 6, m_we = 3;
  bit done = 1'b0;

  psq_top dut (.*);

  always #2.5 clk = ~clk;

  // Bench model of the slot count (R1, R2)
  always @(posedge clk) begin
    if (!rst_n)                   exp_cnt <= 0;
    else if (ext_ctrl && bc_zero) exp_cnt <= 0;
    else if (exp_cnt >= m_pe)     exp_cnt <= 0;
    else                          exp_cnt <= exp_cnt + 1;
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 idle pipe_addr", pipe_addr, exp_cnt);
    end
  endtask

  task automatic load_cfg(input int pe, input int jb, input int we);
    standby = 1'b1; cfg_load = 1'b1;
    cfg_pipe_end = 10'(pe); cfg_jumpback = 10'(jb); cfg_win_end = 7'(we);
    @(negedge clk);
    cfg_load = 1'b0; standby = 1'b0;
    m_pe = pe; m_jb = jb; m_we = we;
  endtask

  function automatic int ext_trig(input int x);
    int t;
    if (x == 0) return m_pe;
    t = 2 * x - 1;
    if (t > m_pe) t = t - (m_pe + 1);
    return t;
  endfunction

  // Starts at a negedge; ends at a negedge with the design idle again
  task automatic run_xfer(input int b, input int x, input bit ovf_try,
                          input bit bcz_mid);
    int size, trig, s, w;
    size = m_pe + 1;
    w    = m_we + 1;
    trig = ext_ctrl ? ext_trig(x) : exp_cnt;
    s    = (trig - m_jb + size) % size;
    xing_num = 9'(x); buf_num = 4'(b); accept = 1'b1;
    @(negedge clk);
    accept = 1'b0;
    for (int k = 0; k < w; k++) begin
      chk("R5 xfer_n low", xfer_n, 0);
      chk("R4 replay addr", pipe_addr, (s + k) % size);
      chk("R6 mem lag", mem_addr, (k == 0) ? 11'h7FF : b * 128 + k - 1);
      chk("R3 trig_addr", trig_addr, trig);
      accept  = ovf_try && (k == 0);
      bc_zero = bcz_mid && (k == 1);
      @(negedge clk);
      accept = 1'b0; bc_zero = 1'b0;
    end
    chk("R5 xfer_n high", xfer_n, 1);
    chk("R8 resume", pipe_addr, exp_cnt);
    chk("R6 last slot", mem_addr, b * 128 + w - 1);
    chk("R7 endcopy", endcopy_addr, (s + m_we) % size);
    if (ovf_try) chk("R11 overflow set", overflow, 1);
    @(negedge clk);
    chk("R6 mem idle", mem_addr, 11'h7FF);
    chk("R8 resume next", pipe_addr, exp_cnt);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset pipe", pipe_addr, 0);
    chk("R5 reset xfer_n", xfer_n, 1);
    chk("R6 reset mem", mem_addr, 11'h7FF);
    chk("R11 reset ovf", overflow, 0);

    // R9 defaults: trigger at 5, jumpback 6 starts at 439
    while (exp_cnt != 5) idle(1);
    run_xfer(2, 0, 1'b0, 1'b0);

    // R9 load ignored outside standby
    cfg_pipe_end = 10'd5; cfg_jumpback = 10'd1; cfg_win_end = 7'd0;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    idle(3);
    run_xfer(1, 0, 1'b0, 1'b0);

    // Sweep over small configurations, local control (R1, R3, R4-R8)
    foreach (m_pe_list[i]) begin
      for (int jb = 0; jb <= m_pe_list[i]; jb += 3) begin
        for (int we = 0; we <= 3; we++) begin
          load_cfg(m_pe_list[i], jb, we);
          idle((jb + we) % 5 + 1);
          run_xfer((jb + we) % 15, 0, 1'b0, 1'b0);
        end
      end
    end

    // External control: crossing numbers, bunch-zero (R2, R3)
    ext_ctrl = 1'b1;
    load_cfg(15, 3, 2);
    bc_zero = 1'b1;
    @(negedge clk);
    bc_zero = 1'b0;
    chk("R2 bunch zero", pipe_addr, 0);
    idle(4);
    for (int x = 0; x <= 9; x++) begin
      run_xfer(x, x, 1'b0, x[0]);
      idle(2);
    end

    // R10 accept in standby ignored
    standby = 1'b1; accept = 1'b1;
    @(negedge clk);
    standby = 1'b0; accept = 1'b0;
    chk("R10 no transfer", xfer_n, 1);
    chk("R10 no overflow", overflow, 0);
    chk("R10 pipe idle", pipe_addr, exp_cnt);

    // R11 accept during transfer, incl. single-entry window
    ext_ctrl = 1'b0;
    load_cfg(9, 2, 0);
    run_xfer(3, 0, 1'b1, 1'b0);
    load_cfg(9, 4, 4);
    run_xfer(5, 0, 1'b1, 1'b0);
    idle(3);
    chk("R11 overflow sticky", overflow, 1);

    finish_run();
  end

  int m_pe_list[2] = '{15, 9};
endmodule